// File: doc/BRIEF.md
# Prescaled Watchdog Timer

This block is a watchdog timer that sits on a simple single-cycle register bus with 32-bit data and word addresses. A two-stage timebase makes the counting tick. The first stage is a prescaler that counts qualifying clock events. The second stage is a divider that counts prescaler wraps. Each tick lowers a down-counter that was loaded from a software-written start value. When the counter reaches zero, the block sets an interrupt flag. If the reset option is on, it also drives a fixed-length reset pulse.

Software keeps the watchdog alive by writing the reload strobe. This copies the start value back into the counter and leaves every other setting as it was. A separate strobe bit restarts the prescaler phase after a new prescale value is written. Writing zero to the control word halts everything. Programming a start value of one and then striking the reload strobe forces an expiry on the next tick. This gives software a way to request an immediate reset.

Top module: `wdt_prescaled`

## Requirements
- R1: After the synchronous active-high reset, every readable register reads 0, and `irq` and `wd_reset` are low.
- R2: With clock select 0, one tick occurs every max(P,1)*max(D,1) clock cycles. P is the prescale word (word 1) and D is the divide word (word 2). The first tick lands that many cycles after the edge that sets the enable bit.
- R3: Each tick lowers the live count (word 5) by one. The count stops at zero and stays there until it is reloaded.
- R4: Writing 1 to bit 0 of the strobe word (word 4) copies the start value (word 3) into the counter at that edge. Word 4 always reads 0. Reloading before expiry prevents expiry and leaves the words 1 to 3 unchanged.
- R5: Writing 1 to bit 1 of word 4 returns the prescaler phase to zero and suppresses the tick at that edge.
- R6: While control bit 0 (enable, word 0) is 0, the count does not change except by reload, and neither the flag nor the reset pulse is raised.
- R7: At expiry (count going 1 to 0), bit 0 of word 7 is set. Writing 1 to that bit clears it. `irq` equals that bit ANDed with bit 0 of word 6.
- R8: If control bit 1 is set at expiry, `wd_reset` goes high on the same edge and stays high for exactly 16 cycles. If control bit 1 is clear, `wd_reset` stays low.
- R9: Bit 0 of word 8 is set whenever expiry drives the reset pulse. Writing 1 to that bit clears it.
- R10: A start value of 1 followed by a reload strobe leads to expiry on the very next tick.
- R11: Word 5 is read-only, and a write to it does not change the count.
- R12: With control bit 2 set, the prescaler advances only in cycles where `slow_tick` is high. Without those pulses, the count does not move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; read data is combinational |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, zero when `bus_rd` is low |
| slow_tick | input | 1 | External slow clock enable, used as the prescaler qualifier when clock select is set |
| irq | output | 1 | Interrupt: flag AND interrupt enable |
| wd_reset | output | 1 | Watchdog reset pulse |

## Verification
The bench uses random prescale, divide and start values with a fixed seed. For each mix it checks the exact cycle of expiry, so an off-by-one in either timebase stage, or in the counter, shows up as a count of 1 or 0 on the wrong cycle. The reset-enable and interrupt-enable bits are also randomised, which separates pulse generation from flag generation. Directed runs cover the cases the random mix does not reach:
- a start value of one
- periodic servicing that must keep the counter from reaching zero
- a disable in the middle of a count
- a write to the read-only count
- counting on the slow qualifier
- a prescaler restart timed so that, without the restart, a tick would land on the very edge of the write

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int REG_AW  = 4;
    localparam int BUS_DW  = 32;

    typedef enum logic [REG_AW-1:0] {
        RA_CTRL = 4'd0,
        RA_PSCL = 4'd1,
        RA_DIVD = 4'd2,
        RA_LOAD = 4'd3,
        RA_STRB = 4'd4,
        RA_CNT  = 4'd5,
        RA_IEN  = 4'd6,
        RA_IFLG = 4'd7,
        RA_STAT = 4'd8
    } reg_addr_e;

    // control word: bit2 clock select, bit1 reset enable, bit0 run
    typedef struct packed {
        logic clk_sel;
        logic rst_en;
        logic en;
    } ctrl_t;

    // single-cycle pulses decoded from bus writes
    typedef struct packed {
        logic reload;
        logic pre_restart;
        logic flag_clr;
        logic stat_clr;
    } bus_pulse_t;

    function automatic bus_pulse_t decode_pulses(input logic wr,
                                                 input logic [REG_AW-1:0] addr,
                                                 input logic [1:0] low_bits);
        bus_pulse_t p;
        p.reload      = wr && (addr == RA_STRB) && low_bits[0];
        p.pre_restart = wr && (addr == RA_STRB) && low_bits[1];
        p.flag_clr    = wr && (addr == RA_IFLG) && low_bits[0];
        p.stat_clr    = wr && (addr == RA_STAT) && low_bits[0];
        return p;
    endfunction

endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
    import wdt_pkg::*;
#(
    parameter int PS_W  = 32,
    parameter int DIV_W = 16,
    parameter int CNT_W = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_wr,
    input  logic                 bus_rd,
    input  logic [REG_AW-1:0]    bus_addr,
    input  logic [BUS_DW-1:0]    bus_wdata,
    output logic [BUS_DW-1:0]    bus_rdata,
    input  logic [CNT_W-1:0]     live_count,
    input  logic                 flag,
    input  logic                 wd_status,
    output ctrl_t                ctrl,
    output logic [PS_W-1:0]      ps_val,
    output logic [DIV_W-1:0]     div_val,
    output logic [CNT_W-1:0]     load_val,
    output logic                 ien,
    output bus_pulse_t           pulses
);

    logic [BUS_DW-1:0] rd_mux;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl     <= '0;
            ps_val   <= '0;
            div_val  <= '0;
            load_val <= '0;
            ien      <= 1'b0;
        end else if (bus_wr) begin
            case (bus_addr)
                RA_CTRL: ctrl     <= ctrl_t'(bus_wdata[2:0]);
                RA_PSCL: ps_val   <= bus_wdata[PS_W-1:0];
                RA_DIVD: div_val  <= bus_wdata[DIV_W-1:0];
                RA_LOAD: load_val <= bus_wdata[CNT_W-1:0];
                RA_IEN:  ien      <= bus_wdata[0];
                default: ;
            endcase
        end
    end

    always_comb begin
        pulses = decode_pulses(bus_wr, bus_addr, bus_wdata[1:0]);
    end

    always_comb begin
        rd_mux = '0;
        case (bus_addr)
            RA_CTRL: rd_mux = BUS_DW'(ctrl);
            RA_PSCL: rd_mux = BUS_DW'(ps_val);
            RA_DIVD: rd_mux = BUS_DW'(div_val);
            RA_LOAD: rd_mux = BUS_DW'(load_val);
            RA_CNT:  rd_mux = BUS_DW'(live_count);
            RA_IEN:  rd_mux = BUS_DW'(ien);
            RA_IFLG: rd_mux = BUS_DW'(flag);
            RA_STAT: rd_mux = BUS_DW'(wd_status);
            default: rd_mux = '0;
        endcase
        bus_rdata = bus_rd ? rd_mux : '0;
    end

endmodule

// File: rtl/wdt_timebase.sv
module wdt_timebase #(
    parameter int PS_W  = 32,
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             qual,
    input  logic             restart,
    input  logic [PS_W-1:0]  ps_val,
    input  logic [DIV_W-1:0] div_val,
    output logic             tick
);

    localparam logic [PS_W-1:0]  PS_ONE  = PS_W'(1);
    localparam logic [DIV_W-1:0] DIV_ONE = DIV_W'(1);

    logic [PS_W-1:0]  pre_cnt;
    logic [DIV_W-1:0] div_cnt;
    logic [PS_W-1:0]  pre_last;
    logic [DIV_W-1:0] div_last;
    logic             pre_hit;
    logic             div_hit;
    logic             advance;

    // a zero limit behaves as a limit of one
    always_comb begin
        pre_last = (ps_val  == '0) ? '0 : ps_val  - PS_ONE;
        div_last = (div_val == '0) ? '0 : div_val - DIV_ONE;
        pre_hit  = (pre_cnt == pre_last);
        div_hit  = (div_cnt == div_last);
        advance  = run && qual && !restart;
        tick     = advance && pre_hit && div_hit;
    end

    always_ff @(posedge clk) begin
        if (rst || restart || !run) begin
            pre_cnt <= '0;
            div_cnt <= '0;
        end else if (advance) begin
            if (pre_hit) begin
                pre_cnt <= '0;
                div_cnt <= div_hit ? '0 : div_cnt + DIV_ONE;
            end else begin
                pre_cnt <= pre_cnt + PS_ONE;
            end
        end
    end

endmodule

// File: rtl/wdt_core.sv
module wdt_core #(
    parameter int CNT_W     = 32,
    parameter int RST_PULSE = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             rst_en,
    input  logic             tick,
    input  logic             reload,
    input  logic [CNT_W-1:0] load_val,
    input  logic             flag_clr,
    input  logic             stat_clr,
    output logic [CNT_W-1:0] count,
    output logic             flag,
    output logic             wd_status,
    output logic             wd_reset
);

    localparam int PW = $clog2(RST_PULSE + 1);
    localparam logic [PW-1:0]    PULSE_LEN = PW'(RST_PULSE);
    localparam logic [CNT_W-1:0] CNT_ONE   = CNT_W'(1);

    logic [PW-1:0] pulse_left;
    logic          expire;

    always_comb begin
        expire   = run && tick && !reload && (count == CNT_ONE);
        wd_reset = (pulse_left != '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (reload) begin
            count <= load_val;
        end else if (run && tick && count != '0) begin
            count <= count - CNT_ONE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= 1'b0;
        end else if (expire) begin
            flag <= 1'b1;
        end else if (flag_clr) begin
            flag <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wd_status  <= 1'b0;
            pulse_left <= '0;
        end else begin
            if (expire && rst_en) begin
                wd_status <= 1'b1;
            end else if (stat_clr) begin
                wd_status <= 1'b0;
            end
            if (expire && rst_en) begin
                pulse_left <= PULSE_LEN;
            end else if (pulse_left != '0) begin
                pulse_left <= pulse_left - PW'(1);
            end
        end
    end

endmodule

// File: rtl/wdt_prescaled.sv
module wdt_prescaled
    import wdt_pkg::*;
#(
    parameter int PS_W      = 32,
    parameter int DIV_W     = 16,
    parameter int CNT_W     = 32,
    parameter int RST_PULSE = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [3:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic        slow_tick,
    output logic        irq,
    output logic        wd_reset
);

    ctrl_t             ctrl_q;
    bus_pulse_t        strobes;
    logic [PS_W-1:0]   ps_q;
    logic [DIV_W-1:0]  div_q;
    logic [CNT_W-1:0]  load_q;
    logic [CNT_W-1:0]  count_q;
    logic              ien_q;
    logic              flag_q;
    logic              stat_q;
    logic              tick;
    logic              qual;

    assign qual = ctrl_q.clk_sel ? slow_tick : 1'b1;
    assign irq  = flag_q && ien_q;

    wdt_regs #(.PS_W(PS_W), .DIV_W(DIV_W), .CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst(rst),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .live_count(count_q), .flag(flag_q), .wd_status(stat_q),
        .ctrl(ctrl_q), .ps_val(ps_q), .div_val(div_q), .load_val(load_q),
        .ien(ien_q), .pulses(strobes)
    );

    wdt_timebase #(.PS_W(PS_W), .DIV_W(DIV_W)) u_timebase (
        .clk(clk), .rst(rst), .run(ctrl_q.en), .qual(qual),
        .restart(strobes.pre_restart), .ps_val(ps_q), .div_val(div_q),
        .tick(tick)
    );

    wdt_core #(.CNT_W(CNT_W), .RST_PULSE(RST_PULSE)) u_core (
        .clk(clk), .rst(rst), .run(ctrl_q.en), .rst_en(ctrl_q.rst_en),
        .tick(tick), .reload(strobes.reload), .load_val(load_q),
        .flag_clr(strobes.flag_clr), .stat_clr(strobes.stat_clr),
        .count(count_q), .flag(flag_q), .wd_status(stat_q),
        .wd_reset(wd_reset)
    );

endmodule

// File: rtl/wdt_checker.sv
module wdt_checker #(
    parameter int CNT_W     = 32,
    parameter int RST_PULSE = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             en,
    input logic             rst_en,
    input logic             reload,
    input logic [CNT_W-1:0] count,
    input logic             flag,
    input logic             ien,
    input logic             irq,
    input logic             wd_status,
    input logic             wd_reset
);

    localparam int HW = $clog2(RST_PULSE + 2);
    logic [HW-1:0] high_len;

    always_ff @(posedge clk) begin
        if (rst) high_len <= '0;
        else if (wd_reset) high_len <= high_len + HW'(1);
        else high_len <= '0;
    end

    // R8: pulse ends after exactly the programmed length
    a_r8_pulse_len: assert property (@(posedge clk) disable iff (rst)
        $fell(wd_reset) |-> high_len == HW'(RST_PULSE));

    // R8: never longer than the programmed length
    a_r8_no_overrun: assert property (@(posedge clk) disable iff (rst)
        (high_len >= HW'(RST_PULSE)) |-> !wd_reset);

    // R8 / R6: a pulse starts only when run and reset-enable were set
    a_r8_needs_enables: assert property (@(posedge clk) disable iff (rst)
        $rose(wd_reset) |-> ($past(en) && $past(rst_en)));

    // R6: disabled and not reloaded -> count frozen
    a_r6_frozen: assert property (@(posedge clk) disable iff (rst)
        (!en && !reload) |=> $stable(count));

    // R6 / R7: flag only rises while running
    a_r6_flag_needs_run: assert property (@(posedge clk) disable iff (rst)
        $rose(flag) |-> $past(en));

    // R3: count holds at zero until reloaded
    a_r3_hold_zero: assert property (@(posedge clk) disable iff (rst)
        (count == '0 && !reload) |=> count == '0);

    // R7: interrupt only with flag and enable
    a_r7_irq_gated: assert property (@(posedge clk) disable iff (rst)
        irq |-> (flag && ien));

    // R9: status is set alongside a new pulse
    a_r9_status_set: assert property (@(posedge clk) disable iff (rst)
        $rose(wd_reset) |-> wd_status);

endmodule

bind wdt_prescaled wdt_checker #(.CNT_W(CNT_W), .RST_PULSE(RST_PULSE)) u_wdt_checker (
    .clk(clk), .rst(rst), .en(ctrl_q.en), .rst_en(ctrl_q.rst_en),
    .reload(strobes.reload), .count(count_q), .flag(flag_q), .ien(ien_q),
    .irq(irq), .wd_status(stat_q), .wd_reset(wd_reset)
);

// File: tb/test_wdt_prescaled.sv
`timescale 1ns/1ps
module test_wdt_prescaled;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        slow_tick = 1'b0;
    logic        irq;
    logic        wd_reset;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #4 clk = ~clk;

    wdt_prescaled i_wdt_prescaled (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .slow_tick(slow_tick), .irq(irq), .wd_reset(wd_reset)
    );

    function automatic int expiry_cycles(input int p, input int d, input int l);
        int pp = (p == 0) ? 1 : p;
        int dd = (d == 0) ? 1 : d;
        return pp * dd * l;
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 4'(a); bus_wdata = 32'(d);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input int a, output int d);
        bus_rd = 1'b1; bus_addr = 4'(a);
        #1;
        d = int'(bus_rdata);
        bus_rd = 1'b0;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_reg(input int a, input int e, input string req);
        int v;
        rd(a, v);
        check(v == e, req, v, e);
    endtask

    initial begin
        repeat (2000000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog timeout actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int seed, v, t, p, d, l, ie, re, hi, cnt_snap;
        seed = $urandom(32'h5EED_0042);
        wait_cyc(3);
        rst = 1'b0;
        wait_cyc(1);

        // R1: reset values
        for (int a = 0; a < 9; a++) expect_reg(a, 0, "R1");
        check(irq == 1'b0, "R1 irq", irq, 0);
        check(wd_reset == 1'b0, "R1 wd_reset", wd_reset, 0);

        // R2 R3 R7 R8 R9 R10: random mixes
        for (int it = 0; it < 8; it++) begin
            p  = (it == 1) ? 0 : int'($urandom_range(4, 1));
            d  = int'($urandom_range(3, 1));
            l  = (it == 0) ? 1 : int'($urandom_range(5, 1));
            ie = int'($urandom_range(1, 0));
            re = (it == 0) ? 1 : int'($urandom_range(1, 0));
            t  = expiry_cycles(p, d, l);
            wr(1, p); wr(2, d); wr(3, l); wr(6, ie);
            wr(4, 3);
            expect_reg(4, 0, "R4 strobe reads zero");
            expect_reg(5, l, "R4 reload copies start");
            wr(0, 1 | (re << 1));
            wait_cyc(t - 1);
            expect_reg(5, 1, "R2 count one before expiry");
            expect_reg(7, 0, "R7 no flag before expiry");
            wait_cyc(1);
            expect_reg(5, 0, (l == 1) ? "R10 single tick expiry" : "R3 count reaches zero");
            expect_reg(7, 1, "R7 flag set");
            check(irq == ie[0], "R7 irq gating", irq, ie);
            check(wd_reset == re[0], "R8 pulse start", wd_reset, re);
            hi = 0;
            while (wd_reset && hi < 40) begin hi++; wait_cyc(1); end
            if (re != 0) begin
                check(hi == 16, "R8 pulse length", hi, 16);
                expect_reg(8, 1, "R9 status set");
                wr(8, 1);
                expect_reg(8, 0, "R9 status cleared");
            end else begin
                expect_reg(8, 0, "R8 R9 no reset without enable");
            end
            wait_cyc(5);
            expect_reg(5, 0, "R3 holds at zero");
            wr(7, 1);
            expect_reg(7, 0, "R7 flag cleared");
            check(irq == 1'b0, "R7 irq after clear", irq, 0);
            wr(0, 0);
        end

        // R6: disable mid-count freezes
        wr(1, 1); wr(2, 1); wr(3, 50); wr(4, 1);
        wr(0, 3);
        wait_cyc(4);
        wr(0, 0);
        rd(5, cnt_snap);
        wait_cyc(30);
        expect_reg(5, cnt_snap, "R6 frozen while disabled");
        expect_reg(7, 0, "R6 no flag while disabled");
        check(wd_reset == 1'b0, "R6 no reset while disabled", wd_reset, 0);

        // R11: write to live count ignored
        wr(5, 12345);
        expect_reg(5, cnt_snap, "R11 count read-only");

        // R4: servicing prevents expiry, settings unchanged
        wr(1, 2); wr(2, 1); wr(3, 4); wr(4, 3);
        wr(0, 1);
        for (int k = 0; k < 10; k++) begin
            wait_cyc(4);
            wr(4, 1);
        end
        expect_reg(7, 0, "R4 serviced no expiry");
        expect_reg(1, 2, "R4 prescale kept");
        expect_reg(2, 1, "R4 divide kept");
        expect_reg(3, 4, "R4 start kept");
        wait_cyc(20);
        expect_reg(7, 1, "R4 expiry once servicing stops");
        wr(0, 0); wr(7, 1);

        // R12: slow qualifier
        wr(1, 1); wr(2, 1); wr(3, 3); wr(4, 1);
        wr(0, 5);
        wait_cyc(20);
        expect_reg(5, 3, "R12 no slow pulses no count");
        for (int k = 0; k < 3; k++) begin
            slow_tick = 1'b1; wait_cyc(1);
            slow_tick = 1'b0; wait_cyc(1);
        end
        expect_reg(5, 0, "R12 three slow pulses");
        expect_reg(7, 1, "R12 flag on slow expiry");
        wr(0, 0); wr(7, 1);

        // R5: prescaler restart shifts the phase
        wr(1, 4); wr(2, 1); wr(3, 2); wr(4, 1);
        wr(0, 1);
        wait_cyc(2);
        wr(4, 2);
        expect_reg(5, 2, "R5 no tick at restart edge");
        wait_cyc(3);
        expect_reg(5, 2, "R5 phase restarted");
        wait_cyc(1);
        expect_reg(5, 1, "R5 tick after full prescale");
        wr(0, 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule